// File: doc/BRIEF.md
# Capacitor-Bank Successive-Approximation Calibrator

This block is the digital half of an RC time-constant calibration loop. It searches for a 5-bit code that selects a binary-weighted capacitor bank. Bit 4 carries a weight of 16 units, bit 3 carries 8, bit 2 carries 4, bit 1 carries 2 and bit 0 carries 1. The bank always includes a fixed part of 16 units. During the search, a trial code drives a replica bank inside an external measurement circuit. A comparator reports back one bit. A 1 means the replica voltage is above the reference, so the bank is too small. A 0 means the voltage is below the reference, so the bank is too large.

The search works from the most significant bit down to the least significant bit and resolves one bit per step. Before each step, the trial code is held for a programmable number of settle cycles. The comparator input passes through a two-flop synchronizer before it is used. The filter's own capacitor banks are driven by a separate held code. That code changes only in the cycle where the last bit is decided, and a one-cycle done pulse marks the change.

Top module: `cap_sar_cal`

## Requirements
- R1: After reset, both `trial_code_o` and `filter_code_o` are 10000, and `busy_o` and `done_o` are 0.
- R2: A `start_i` sampled high while idle loads `trial_code_o` with 10000 and raises `busy_o` on the same clock edge.
- R3: At a decision, a comparator value of 1 keeps the bit under test at 1 and sets the next lower bit. From 10000 the result is 11000.
- R4: At a decision, a comparator value of 0 clears the bit under test and sets the next lower bit. From 10000 the result is 01000.
- R5: Each trial code is held for `SETTLE_CYC` cycles (default 4) before its decision. `done_o` therefore rises exactly 5*`SETTLE_CYC` clock edges after the edge that accepted start.
- R6: The final code is the trial code with only the LSB kept or cleared. No bit is set after the LSB. With a comparator that reports 1 while the code is below a target T, the result is T-1, clipped to the range 0..31.
- R7: `filter_code_o` changes only in the cycle in which `done_o` is high. It holds its value through a later search until that search completes.
- R8: `done_o` is high for exactly one cycle. `busy_o` is low in that cycle.
- R9: `start_i` has no effect while `busy_o` is high. The search in progress continues and ends with the same code and the same latency.
- R10: A decision uses the comparator value that was present two clock edges before the decision edge. A change that arrives in the last cycle before the decision edge does not affect that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration request, sampled on a rising edge |
| cmp_i | input | 1 | Comparator result, asynchronous. 1 means the replica voltage is above the reference |
| trial_code_o | output | 5 | Code driven to the replica bank during the search |
| filter_code_o | output | 5 | Held code driven to the filter capacitor banks |
| busy_o | output | 1 | High while a search is in progress |
| done_o | output | 1 | One-cycle pulse when `filter_code_o` updates |

## Verification
The case that is hardest to reach from the ports is a comparator change that lands inside the synchronizer window just before a decision edge. A comparator model that simply follows the trial code can never produce it. To create it, the bench disconnects its comparator model and drives the comparator directly. It holds 0 through the first two edges after start, then switches to 1 only after the edge that precedes the decision by two cycles, and checks that the first bit is still cleared. A second hard case is a start pulse raised while a search is in flight. The bench checks this through the unchanged final code and the unchanged latency.

// File: rtl/cap_sar_pkg.sv
package cap_sar_pkg;

    localparam int CAL_CODE_W_DEF = 5;
    localparam int CAL_SETTLE_DEF = 4;

    typedef enum logic {
        CAL_IDLE = 1'b0,
        CAL_RUN  = 1'b1
    } cal_state_e;

    // Result of one bit step: the next code and whether it was the last bit
    typedef struct packed {
        logic [CAL_CODE_W_DEF-1:0] code;
        logic                      last;
    } cal_step_t;

endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[k] <= 1'b0;
                    else     chain_q[k] <= chain_q[k-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic restart_i,
    output logic decide_o
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i || !run_i) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    assign decide_o = run_i && (cnt_q == CNT_LAST);

    // R5: between restarts the wait counter advances by one each cycle
    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (run_i && !restart_i) |=> (!run_i || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cal_sar_core.sv
module cal_sar_core
    import cap_sar_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              decide_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] trial_o,
    output logic [CODE_W-1:0] final_o,
    output logic              running_o,
    output logic              finish_o
);
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [IDX_W-1:0]  IDX_TOP = IDX_W'(CODE_W - 1);
    localparam logic [CODE_W-1:0] MID     = {1'b1, {(CODE_W-1){1'b0}}};

    cal_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CODE_W-1:0] trial_q;
    logic [CODE_W-1:0] step_code;
    logic              step_last;

    always_comb begin
        step_code         = trial_q;
        step_code[idx_q]  = cmp_i;
        step_last         = (idx_q == '0);
        if (!step_last) step_code[idx_q - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAL_IDLE;
            idx_q   <= IDX_TOP;
            trial_q <= MID;
        end else begin
            case (state_q)
                CAL_IDLE: begin
                    if (load_i) begin
                        trial_q <= MID;
                        idx_q   <= IDX_TOP;
                        state_q <= CAL_RUN;
                    end
                end
                default: begin
                    if (decide_i) begin
                        trial_q <= step_code;
                        if (step_last) state_q <= CAL_IDLE;
                        else           idx_q   <= idx_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign trial_o   = trial_q;
    assign final_o   = step_code;
    assign running_o = (state_q == CAL_RUN);
    assign finish_o  = (state_q == CAL_RUN) && decide_i && step_last;

    // R2: an accepted start loads mid-scale and enters the search
    p_mid_load_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAL_IDLE && load_i) |=> (trial_q == MID && state_q == CAL_RUN));
    // R3: a high comparator never lowers the code
    p_keep_up_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAL_RUN && decide_i && cmp_i) |=> (trial_q >= $past(trial_q)));
    // R4: a low comparator always lowers the code
    p_clear_down_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAL_RUN && decide_i && !cmp_i) |=> (trial_q < $past(trial_q)));
    // R5: the trial code is held between decisions
    p_trial_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAL_RUN && !decide_i) |=> $stable(trial_q));
endmodule

// File: rtl/cap_sar_cal.sv
module cap_sar_cal
    import cap_sar_pkg::*;
#(
    parameter int CODE_W      = CAL_CODE_W_DEF,
    parameter int SETTLE_CYC  = CAL_SETTLE_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] trial_code_o,
    output logic [CODE_W-1:0] filter_code_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic              cmp_sync;
    logic              running;
    logic              start_acc;
    logic              decide;
    logic              finish;
    logic [CODE_W-1:0] final_code;
    logic [CODE_W-1:0] filt_q;
    logic              done_q;

    assign start_acc = start_i && !running;

    cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_i),
        .q_o (cmp_sync)
    );

    cal_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (running),
        .restart_i (start_acc || decide),
        .decide_o  (decide)
    );

    cal_sar_core #(.CODE_W(CODE_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load_i    (start_acc),
        .decide_i  (decide),
        .cmp_i     (cmp_sync),
        .trial_o   (trial_code_o),
        .final_o   (final_code),
        .running_o (running),
        .finish_o  (finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= MID;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) filt_q <= final_code;
        end
    end

    assign filter_code_o = filt_q;
    assign busy_o        = running;
    assign done_o        = done_q;

    // R7: the filter code moves only together with done
    p_filter_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(filt_q));
    // R8: done is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R8: busy has dropped when done is shown
    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !running);
    // R9: a start during a search does not end it early
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (running && start_i && !finish) |=> running);
endmodule

// File: tb/sim_cap_sar_cal.sv
`timescale 1ns/1ps
module sim_cap_sar_cal;
    localparam int SETTLE = 4;
    localparam int LAT    = 5 * SETTLE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       use_model = 1'b1;
    logic       cmp_man = 1'b0;
    logic [5:0] target = 6'd0;
    logic       cmp;
    logic [4:0] trial, filt;
    logic       busy, done;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    // Comparator model: the bank is too small while the code is below the target
    assign cmp = use_model ? ({1'b0, trial} < target) : cmp_man;

    cap_sar_cal u0 (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .cmp_i         (cmp),
        .trial_code_o  (trial),
        .filter_code_o (filt),
        .busy_o        (busy),
        .done_o        (done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    // Waits for done; counts edges since the start edge and checks the filter code is held
    task automatic wait_done(output int cyc, input logic [4:0] held);
        cyc = 0;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk);
            #1 cyc++;
            if (done) break;
            check("R7 filter held during search", filt, held);
        end
    endtask

    function automatic int expect_code(input int t);
        if (t == 0) return 0;
        if (t > 32) return 31;
        return t - 1;
    endfunction

    task automatic t_reset();
        check("R1 trial after reset", trial, 5'b10000);
        check("R1 filter after reset", filt, 5'b10000);
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);
    endtask

    task automatic t_first_step(input int t, input int exp_step, input string req);
        int cyc;
        logic [4:0] held;
        held = filt;
        target = 6'(t);
        pulse_start();
        check("R2 mid-scale load", trial, 5'b10000);
        check("R2 busy raised", busy, 1);
        for (int i = 0; i < SETTLE; i++) @(posedge clk);
        #1 check(req, trial, exp_step);
        wait_done(cyc, held);
    endtask

    task automatic t_full(input int t);
        int cyc;
        logic [4:0] held;
        held = filt;
        target = 6'(t);
        pulse_start();
        wait_done(cyc, held);
        check("R5 latency", cyc, LAT - 0);
        check("R6 final filter code", filt, expect_code(t));
        check("R8 busy low with done", busy, 0);
        @(posedge clk);
        #1 check("R8 done single cycle", done, 0);
        check("R7 filter kept after done", filt, expect_code(t));
    endtask

    task automatic t_start_ignored();
        int cyc;
        logic [4:0] held;
        held = filt;
        target = 6'd22;
        pulse_start();
        for (int i = 0; i < 6; i++) @(posedge clk);
        #1;
        pulse_start();
        check("R9 trial not reloaded", trial != 5'b10000, 1);
        wait_done(cyc, held);
        check("R9 latency unchanged", cyc, LAT - 7);
        check("R9 final code", filt, expect_code(22));
    endtask

    task automatic t_sync_window();
        int cyc;
        logic [4:0] held;
        held = filt;
        use_model = 1'b0;
        cmp_man = 1'b0;
        pulse_start();
        @(posedge clk);
        @(posedge clk);
        #1 cmp_man = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 check("R10 late comparator change not used", trial, 5'b01000);
        wait_done(cyc, held);
        check("R10 later bits follow comparator", filt, 5'b01111);
        use_model = 1'b1;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_first_step(32, 5'b11000, "R3 keep bit on high comparator");
        t_first_step(0, 5'b01000, "R4 clear bit on low comparator");
        t_full(32);
        t_full(0);
        t_full(17);
        t_full(9);
        t_full(20);
        t_start_ignored();
        t_sync_window();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule